// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block lets on-chip logic reach an external asynchronous static RAM of 262,144 words of 16 bits. A client offers one access at a time over a valid/ready handshake. Each request carries an 18-bit word address, a read/write flag, 16 bits of write data and a two-bit lane mask. Mask bit 0 selects bits 7:0 and mask bit 1 selects bits 15:8. The controller drives the memory's active-low select, write strobe, output enable and per-lane enables from registers. It owns the 18-bit address bus and the shared 16-bit data bus.

Timing comes from three parameters: the clock period, the memory's address-to-data access time and the minimum write-strobe width. The controller turns these into whole clock-cycle counts. With the defaults (8 ns clock, 12 ns access time, 9 ns strobe width), a read waits 3 cycles and the write strobe is low for 2 cycles. A completion pulse ends every access. On a read, the same pulse carries the captured data.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and right after reset, `memCeN`, `memWeN` and `memOeN` are high, `memBeN` is 2'b11, `reqReady` is high and `rspValid` is low.
- R2: An accepted write with a nonzero mask runs these cycles in order:
  - one cycle with `memCeN` low and `memWeN` high;
  - WR_PULSE cycles with `memWeN` low (default 2);
  - one cycle with `memWeN` high again and `memCeN` still low.
  `memOeN` stays high the whole time.
- R3: From the first cycle of a write to its last, `memAddr` holds the request address and `memDq` carries the request write data. Address and data are therefore set up one cycle before the write strobe falls and held one cycle after it rises. During a read, `memAddr` holds the request address.
- R4: While `memCeN` is low, `memBeN[0]` is the inverse of mask bit 0 and `memBeN[1]` is the inverse of mask bit 1. Only the enabled lanes are written to or read from the memory.
- R5: An accepted read with a nonzero mask holds `memCeN` and `memOeN` low and `memWeN` high for RD_WAIT cycles (default 3).
- R6: After the last read cycle, `rspValid` is high for exactly one cycle. In that cycle `reqReady` is high, and `rspData` holds the memory word with every disabled lane returned as zero.
- R7: A request with mask 2'b00 is a no-op. It keeps `memCeN` high for one busy cycle, then pulses `rspValid` and leaves the memory unchanged.
- R8: `reqReady` falls in the cycle after acceptance and stays low until the completion cycle. Request inputs offered while busy are ignored.
- R9: The controller drives `memDq` only during the three write phases. Everywhere else the bus is released, and `memWeN` and `memOeN` are never low together.
- R10: Whenever the controller is idle, `memCeN` is high, so the memory drops into its own standby.
- R11: A write also finishes with a one-cycle `rspValid` pulse. It comes in the cycle after the hold cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller idle and able to accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane mask; bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rspValid | output | 1 | One-cycle completion pulse |
| rspData | output | 16 | Read data, valid together with rspValid after a read |
| memAddr | output | 18 | Memory address bus |
| memCeN | output | 1 | Memory select, active low |
| memWeN | output | 1 | Write strobe, active low |
| memOeN | output | 1 | Output enable, active low |
| memBeN | output | 2 | Lane enables, active low; bit 1 = bits 15:8 |
| memDq | inout | 16 | Shared data bus |

## Verification
On every cycle, the assertions check the pin-level safety rules:
- the write strobe only falls inside a selected access, with the address already steady;
- the strobe rises with the select, drive and address unchanged;
- the bus is driven only while output enable is high;
- the memory is deselected whenever the controller is ready;
- completion is a single pulse taken while ready.

Only the bench can show the exact phase lengths, the lane enable values, and the lane merging of partial writes seen through a later read-back. It also shows no-op requests leaving the memory untouched, and back-to-back requests offered while busy being ignored. For these, the bench keeps a behavioural memory model and compares an expected cycle queue against the outputs on every clock.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NOP,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RWAIT
  } stateT;

  // Strobes from control to datapath; output strobes describe the next cycle.
  typedef struct packed {
    logic ceOn;
    logic weOn;
    logic oeOn;
    logic laneOn;
    logic dqDrive;
    logic busy;
    logic latchReq;
    logic capture;
    logic done;
  } ctrlT;

endpackage

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int WR_PULSE = 2,
  parameter int RD_WAIT  = 3,
  parameter int LANES    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LANES-1:0] reqMask,
  output ctrlT             ctrl
);

  localparam int MAX_CYC = (WR_PULSE > RD_WAIT) ? WR_PULSE : RD_WAIT;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_PULSE - 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_WAIT - 1);

  stateT            state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    ctrl     = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctrl.latchReq = 1'b1;
          cntNxt        = '0;
          if (reqMask == '0)  stateNxt = ST_NOP;
          else if (reqWrite)  stateNxt = ST_WSETUP;
          else                stateNxt = ST_RWAIT;
        end
      end
      ST_NOP: begin
        stateNxt  = ST_IDLE;
        ctrl.done = 1'b1;
      end
      ST_WSETUP: begin
        stateNxt = ST_WPULSE;
        cntNxt   = '0;
      end
      ST_WPULSE: begin
        if (cnt == WR_LAST) stateNxt = ST_WHOLD;
        else                cntNxt   = cnt + 1'b1;
      end
      ST_WHOLD: begin
        stateNxt  = ST_IDLE;
        ctrl.done = 1'b1;
      end
      ST_RWAIT: begin
        if (cnt == RD_LAST) begin
          stateNxt     = ST_IDLE;
          ctrl.capture = 1'b1;
          ctrl.done    = 1'b1;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase

    ctrl.busy    = (stateNxt != ST_IDLE);
    ctrl.dqDrive = (stateNxt inside {ST_WSETUP, ST_WPULSE, ST_WHOLD});
    ctrl.ceOn    = ctrl.dqDrive || (stateNxt == ST_RWAIT);
    ctrl.weOn    = (stateNxt == ST_WPULSE);
    ctrl.oeOn    = (stateNxt == ST_RWAIT);
    ctrl.laneOn  = ctrl.ceOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

endmodule

// File: rtl/sram_lane_dp.sv
module sram_lane_dp
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlT                ctrl,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqMask,
  input  logic [DATA_W-1:0]   dqIn,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memCeN,
  output logic                memWeN,
  output logic                memOeN,
  output logic [DATA_W/8-1:0] memBeN,
  output logic [DATA_W-1:0]   dqOut,
  output logic                dqOe,
  output logic                reqReady,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData
);

  localparam int LANE_W = 8;
  localparam int LANES  = DATA_W / LANE_W;

  logic [LANES-1:0] maskQ;
  logic [LANES-1:0] maskSel;

  assign maskSel = ctrl.latchReq ? reqMask : maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCeN   <= 1'b1;
      memWeN   <= 1'b1;
      memOeN   <= 1'b1;
      dqOe     <= 1'b0;
      reqReady <= 1'b1;
      rspValid <= 1'b0;
      memAddr  <= '0;
      dqOut    <= '0;
      maskQ    <= '0;
    end else begin
      memCeN   <= ~ctrl.ceOn;
      memWeN   <= ~ctrl.weOn;
      memOeN   <= ~ctrl.oeOn;
      dqOe     <= ctrl.dqDrive;
      reqReady <= ~ctrl.busy;
      rspValid <= ctrl.done;
      if (ctrl.latchReq) begin
        memAddr <= reqAddr;
        dqOut   <= reqWdata;
        maskQ   <= reqMask;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic              beQ;
    logic [LANE_W-1:0] rdQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        beQ <= 1'b1;
        rdQ <= '0;
      end else begin
        beQ <= ~(ctrl.laneOn & maskSel[g]);
        if (ctrl.capture) rdQ <= maskQ[g] ? dqIn[g*LANE_W +: LANE_W] : '0;
      end
    end

    assign memBeN[g]                    = beQ;
    assign rspData[g*LANE_W +: LANE_W]  = rdQ;
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_PS = 8000,
  parameter int ACCESS_PS     = 12000,
  parameter int WE_WIDTH_PS   = 9000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqMask,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memCeN,
  output logic                memWeN,
  output logic                memOeN,
  output logic [DATA_W/8-1:0] memBeN,
  inout  wire  [DATA_W-1:0]   memDq
);

  localparam int LANES    = DATA_W / 8;
  // One extra cycle covers output register delay and input capture margin.
  localparam int RD_WAIT  = (ACCESS_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS + 1;
  localparam int WR_RAW   = (WE_WIDTH_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int WR_PULSE = (WR_RAW < 1) ? 1 : WR_RAW;

  ctrlT              ctrl;
  logic [DATA_W-1:0] dqOut;
  logic [DATA_W-1:0] dqIn;
  logic              dqOe;

  assign memDq = dqOe ? dqOut : {DATA_W{1'bz}};
  assign dqIn  = memDq;

  sram_lane_fsm #(
    .WR_PULSE(WR_PULSE),
    .RD_WAIT (RD_WAIT),
    .LANES   (LANES)
  ) i_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqMask (reqMask),
    .ctrl    (ctrl)
  );

  sram_lane_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .dqIn    (dqIn),
    .memAddr (memAddr),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN),
    .memBeN  (memBeN),
    .dqOut   (dqOut),
    .dqOe    (dqOe),
    .reqReady(reqReady),
    .rspValid(rspValid),
    .rspData (rspData)
  );

endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
  parameter int ADDR_W = 18,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic [LANES-1:0]  memBeN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              dqOe
);

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCeN); // R2

  AST_SETUP_BEFORE_WE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> ($past(!memCeN) && $past(dqOe) && $stable(memAddr))); // R3

  AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (!memCeN && dqOe && $stable(memAddr) && $stable(memBeN))); // R3

  AST_LANE_WITH_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    !memCeN |-> (memBeN != '1)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R6

  AST_DONE_WHEN_READY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> reqReady); // R6

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R8

  AST_WE_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN); // R9

  AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> (memOeN && !memCeN)); // R9

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && memWeN && memOeN)); // R10

endmodule

bind sram_lane_ctrl sram_lane_chk #(
  .ADDR_W(ADDR_W),
  .LANES (LANES)
) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .rspValid(rspValid),
  .memCeN  (memCeN),
  .memWeN  (memWeN),
  .memOeN  (memOeN),
  .memBeN  (memBeN),
  .memAddr (memAddr),
  .dqOe    (dqOe)
);

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;

  localparam int WR = 2;  // R2 default strobe length
  localparam int RD = 3;  // R5 default read wait

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic        reqReady, rspValid;
  logic [15:0] rspData;
  logic [17:0] memAddr;
  logic        memCeN, memWeN, memOeN;
  logic [1:0]  memBeN;
  wire  [15:0] memDq;

  always #4 clk = ~clk;

  sram_lane_ctrl i_sram_lane_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr), .memCeN(memCeN),
    .memWeN(memWeN), .memOeN(memOeN), .memBeN(memBeN), .memDq(memDq)
  );

  // Behavioural memory responder
  logic [15:0] sramMem [logic [17:0]];
  logic [15:0] rdWord;
  int          wrCount = 0;
  logic        rdOn;

  always @(memAddr or wrCount)
    rdWord = sramMem.exists(memAddr) ? sramMem[memAddr] : 16'h0000;

  assign rdOn = !memCeN && !memOeN && memWeN;
  assign memDq[7:0]  = (rdOn && !memBeN[0]) ? rdWord[7:0]  : 8'hzz;
  assign memDq[15:8] = (rdOn && !memBeN[1]) ? rdWord[15:8] : 8'hzz;

  always @(posedge memWeN) begin
    if (rstN && !memCeN) begin
      logic [15:0] w;
      w = sramMem.exists(memAddr) ? sramMem[memAddr] : 16'h0000;
      if (!memBeN[0]) w[7:0]  = memDq[7:0];
      if (!memBeN[1]) w[15:8] = memDq[15:8];
      sramMem[memAddr] = w;
      wrCount++;
    end
  end

  // Reference model: queue of expected per-cycle output values
  typedef struct {
    logic        ceN, weN, oeN;
    logic [1:0]  beN;
    logic        drv, rdy, done, chkData;
    logic [15:0] data, wd;
    logic [17:0] addr;
    string       tag;
  } expT;

  expT         expQ[$];
  logic [15:0] shadow [logic [17:0]];
  int          nChecks = 0;
  int          nFail = 0;
  logic        curReady = 1'b1;
  string       idleTag = "R1";
  bit          finished = 0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic expT mk(input logic ceN, weN, oeN, input logic [1:0] beN,
                             input logic drv, rdy, done, input string tag);
    expT e;
    e.ceN = ceN; e.weN = weN; e.oeN = oeN; e.beN = beN;
    e.drv = drv; e.rdy = rdy; e.done = done; e.chkData = 1'b0;
    e.data = '0; e.wd = '0; e.addr = '0; e.tag = tag;
    return e;
  endfunction

  task automatic step();
    expT e;
    @(negedge clk);
    if (expQ.size() != 0) e = expQ.pop_front();
    else e = mk(1, 1, 1, 2'b11, 0, 1, 0, idleTag);
    check(e.tag, "ce/we/oe/done", {memCeN, memWeN, memOeN, rspValid},
          {e.ceN, e.weN, e.oeN, e.done});
    check("R8", "ready", reqReady, e.rdy);
    check("R4", "lane enables", memBeN, e.beN);
    if (!e.ceN) check("R3", "address", memAddr, e.addr);
    if (e.drv)  check("R3", "bus write data", memDq, e.wd);
    if (e.chkData) check("R6 R9", "read data", rspData, e.data);
    curReady = e.rdy;
  endtask

  // Offer a request; stays offered while busy (R8), accepted when ready.
  task automatic issue(input logic w, input logic [17:0] a,
                       input logic [15:0] d, input logic [1:0] m);
    expT e;
    logic [15:0] old, lm;
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d; reqMask = m;
    while (!curReady) step();
    old = shadow.exists(a) ? shadow[a] : 16'h0000;
    lm  = {{8{m[1]}}, {8{m[0]}}};
    if (m == 2'b00) begin
      expQ.push_back(mk(1, 1, 1, 2'b11, 0, 0, 0, "R7"));
      expQ.push_back(mk(1, 1, 1, 2'b11, 0, 1, 1, "R7"));
    end else if (w) begin
      e = mk(0, 1, 1, ~m, 1, 0, 0, "R2"); e.addr = a; e.wd = d; expQ.push_back(e);
      for (int i = 0; i < WR; i++) begin
        e = mk(0, 0, 1, ~m, 1, 0, 0, "R2"); e.addr = a; e.wd = d; expQ.push_back(e);
      end
      e = mk(0, 1, 1, ~m, 1, 0, 0, "R3"); e.addr = a; e.wd = d; expQ.push_back(e);
      expQ.push_back(mk(1, 1, 1, 2'b11, 0, 1, 1, "R11"));
      shadow[a] = (old & ~lm) | (d & lm);
    end else begin
      for (int i = 0; i < RD; i++) begin
        e = mk(0, 1, 0, ~m, 0, 0, 0, "R5"); e.addr = a; expQ.push_back(e);
      end
      e = mk(1, 1, 1, 2'b11, 0, 1, 1, "R6"); e.chkData = 1'b1; e.data = old & lm;
      expQ.push_back(e);
    end
    step();
    reqWdata = ~d; reqAddr = a ^ 18'h155;  // scrambled while busy (R8)
  endtask

  task automatic idle(input int n);
    reqValid = 1'b0;
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int seed = 7;
    rstN = 1'b0;
    repeat (3) step();                 // R1 during reset
    rstN = 1'b1;
    repeat (2) step();                 // R1 after release
    idleTag = "R10";

    issue(1, 18'h00005, 16'hA5C3, 2'b11);
    idle(2);
    issue(0, 18'h00005, 16'h0000, 2'b11);  // R6 expects A5C3
    idle(1);
    issue(1, 18'h00005, 16'h1122, 2'b01);  // R4 low lane only
    issue(0, 18'h00005, 16'h0000, 2'b11);  // expects A522
    issue(1, 18'h3FFFF, 16'hBEEF, 2'b10);  // R4 high lane only
    issue(0, 18'h3FFFF, 16'h0000, 2'b01);  // disabled lane zero
    issue(0, 18'h3FFFF, 16'h0000, 2'b10);  // expects BE00
    idle(1);
    issue(1, 18'h00005, 16'hFFFF, 2'b00);  // R7 no-op write
    issue(0, 18'h00005, 16'h0000, 2'b00);  // R7 no-op read
    issue(0, 18'h00005, 16'h0000, 2'b11);  // still A522
    idle(2);

    for (int k = 0; k < 40; k++) begin
      logic [17:0] a;
      seed = seed * 1103515245 + 12345;
      case (seed[17:16])
        2'd0: a = 18'h00000;
        2'd1: a = 18'h00001;
        2'd2: a = 18'h2AAAA;
        default: a = 18'h3FFFF;
      endcase
      issue(seed[20], a, seed[31:16] ^ seed[15:0], seed[23:22]);
      if (seed[25]) idle(1);
    end
    idle(4);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule